// File: doc/BRIEF.md
# Serial LED Chain Driver

This peripheral refreshes a chain of external 8-bit serial-in, parallel-out registers, usually wired to status LEDs. It drives three pins: a serial data line, a shift clock, and a store strobe that copies the shifted pattern to the register outputs. Software reaches it through a small 32-bit register bus. An update is one frame on the pins. Software can start a frame with a trigger bit, or a rate timer can start frames at a fixed period.

The frame length depends on how many 8-bit groups are enabled. Any of the low eight output bits can be taken from side-band status inputs instead of the data register. Two bits come from a modem status source. Three bits come from a first PHY. Three more bits come from a second PHY. Each override has its own enable bit. The shift clock polarity can be set so that the external registers capture data on either the rising or the falling edge.

The sequencer has five states. IDLE waits for work. SETUP presents a bit with the clock in its inactive level. CAPTURE drives the active clock level. STORE_A and STORE_B hold the strobe. Its transitions are:

- IDLE to SETUP on a trigger or a pending request, when at least one group is enabled.
- SETUP to CAPTURE always.
- CAPTURE to SETUP while bits remain.
- CAPTURE to STORE_A after the last bit.
- STORE_A to STORE_B.
- STORE_B to IDLE.

Top module: `led_shift_ctrl`

## Requirements
- R1: After reset, every register reads zero, the store strobe and data line are low, and the shift clock sits at its idle level, which is low when the edge bit is 0.
- R2: Registers at word offsets 0x00 (control A), 0x04 (control B), 0x08 (pattern), 0x0C and 0x10 (spare words) read back the last full 32-bit value written. Any other offset reads zero.
- R3: A frame carries 8, 16 or 24 bits when the highest set bit among control B bits [2:0] is bit 0, bit 1 or bit 2. With no group bit set, a request is dropped and the pins stay idle.
- R4: Bits leave most significant first, one per SETUP/CAPTURE pair. The data line is steady across the capturing clock transition and is low outside a frame.
- R5: A bus write to control A with bit 31 set starts one frame of the pattern register.
- R6: Control A bit 26 set to 0 makes the idle clock level low, so data is captured on the rising edge. Set to 1, the idle level is high and capture is on the falling edge. The value is latched at frame start.
- R7: Control A bits [25:24] enable replacing output bits 1:0 with the modem status inputs.
- R8: Control A bits [29:27] enable replacing output bits 4:2 with the first PHY inputs. Control B bits [17:15] enable replacing output bits 7:5 with the second PHY inputs. Override values are sampled at frame start.
- R9: In periodic mode, frames start every D bus cycles. D is the divider parameter picked by control B bits [24:23]: codes 00, 01, 10 and 11 stand for 2, 4, 8 and 10 Hz.
- R10: Periodic mode is active only when control B bits [31:30] equal binary 10. Any other value stops periodic frames and clears the rate counter.
- R11: After the last bit, the store strobe is high for exactly two bus cycles (one shift-clock period), with the clock at its idle level.
- R12: Requests arriving during a frame are merged into one pending request, which starts one further frame after the current frame returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Byte offset of register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| modem_led | input | 2 | Modem status override values |
| phy_a_led | input | 3 | First PHY override values |
| phy_b_led | input | 3 | Second PHY override values |
| ser_data | output | 1 | Serial data to the chain |
| ser_clk | output | 1 | Shift clock |
| ser_store | output | 1 | Store strobe |

## Verification
The assertions assume that the edge-select bit changes only while the sequencer is idle. They read it live to decide which clock transition is the capturing one. The stimulus therefore writes the edge bit only while no frame is running. The stimulus also waits for the whole frame, strobe included, before rewriting group enables or override enables whose effect a check depends on.

// File: rtl/stp_pkg.sv
package stp_pkg;
    localparam int unsigned ADDR_W = 5;
    localparam logic [ADDR_W-1:0] ADDR_CTRL_A = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_CTRL_B = 5'h04;
    localparam logic [ADDR_W-1:0] ADDR_PATTERN = 5'h08;
    localparam logic [ADDR_W-1:0] ADDR_SPARE0 = 5'h0C;
    localparam logic [ADDR_W-1:0] ADDR_SPARE1 = 5'h10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CAPTURE,
        ST_STORE_A,
        ST_STORE_B
    } seq_state_t;
endpackage

// File: rtl/stp_regs.sv
module stp_regs
    import stp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       ctrl_a,
    output logic [31:0]       ctrl_b,
    output logic [31:0]       pattern,
    output logic              sw_trig
);
    logic [31:0] spare0, spare1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_a  <= '0;
            ctrl_b  <= '0;
            pattern <= '0;
            spare0  <= '0;
            spare1  <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                ADDR_CTRL_A:  ctrl_a  <= bus_wdata;
                ADDR_CTRL_B:  ctrl_b  <= bus_wdata;
                ADDR_PATTERN: pattern <= bus_wdata;
                ADDR_SPARE0:  spare0  <= bus_wdata;
                ADDR_SPARE1:  spare1  <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL_A:  bus_rdata = ctrl_a;
            ADDR_CTRL_B:  bus_rdata = ctrl_b;
            ADDR_PATTERN: bus_rdata = pattern;
            ADDR_SPARE0:  bus_rdata = spare0;
            ADDR_SPARE1:  bus_rdata = spare1;
            default:      bus_rdata = '0;
        endcase
    end

    assign sw_trig = bus_wr && (bus_addr == ADDR_CTRL_A) && bus_wdata[31];
endmodule

// File: rtl/stp_rate_timer.sv
module stp_rate_timer #(
    parameter int unsigned DIV_R0 = 50_000_000,
    parameter int unsigned DIV_R1 = 25_000_000,
    parameter int unsigned DIV_R2 = 12_500_000,
    parameter int unsigned DIV_R3 = 10_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int unsigned CNT_W = 32;
    logic [CNT_W-1:0] count, limit;

    always_comb begin
        unique case (rate)
            2'd0: limit = CNT_W'(DIV_R0);
            2'd1: limit = CNT_W'(DIV_R1);
            2'd2: limit = CNT_W'(DIV_R2);
            default: limit = CNT_W'(DIV_R3);
        endcase
    end

    assign tick = enable && (count == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (!enable) count <= '0;
        else if (tick)    count <= '0;
        else              count <= count + 1'b1;
    end
endmodule

// File: rtl/stp_shifter.sv
module stp_shifter
    import stp_pkg::*;
#(
    parameter int unsigned GROUP_W = 8,
    parameter int unsigned NGROUPS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_req,
    input  logic [NGROUPS-1:0]         groups,
    input  logic [GROUP_W*NGROUPS-1:0] frame,
    input  logic                       fall_cfg,
    output logic                       busy,
    output logic                       ser_data,
    output logic                       ser_clk,
    output logic                       ser_store
);
    localparam int unsigned MAX_BITS = GROUP_W * NGROUPS;
    localparam int unsigned CW = $clog2(MAX_BITS + 1);

    seq_state_t state, nxt;
    logic [MAX_BITS-1:0] shreg;
    logic [CW-1:0] remain, nbits, gap;
    logic pend, fall_q, go;

    always_comb begin
        nbits = '0;
        for (int g = 0; g < NGROUPS; g++)
            if (groups[g]) nbits = CW'(GROUP_W * (g + 1));
        gap = CW'(MAX_BITS) - nbits;
    end

    assign go = start_req || pend;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (go && nbits != '0) nxt = ST_SETUP;
            ST_SETUP:   nxt = ST_CAPTURE;
            ST_CAPTURE: nxt = (remain == CW'(1)) ? ST_STORE_A : ST_SETUP;
            ST_STORE_A: nxt = ST_STORE_B;
            ST_STORE_B: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            remain <= '0;
            fall_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            if (state == ST_IDLE) begin
                pend <= 1'b0;
                if (go && nbits != '0) begin
                    shreg  <= frame << gap;
                    remain <= nbits;
                    fall_q <= fall_cfg;
                end
            end else begin
                if (start_req) pend <= 1'b1;
                if (state == ST_CAPTURE) begin
                    shreg  <= shreg << 1;
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        ser_data  = 1'b0;
        ser_clk   = fall_cfg;
        ser_store = 1'b0;
        unique case (state)
            ST_IDLE:    ser_clk = fall_cfg;
            ST_SETUP:   begin ser_data = shreg[MAX_BITS-1]; ser_clk = fall_q; end
            ST_CAPTURE: begin ser_data = shreg[MAX_BITS-1]; ser_clk = !fall_q; end
            ST_STORE_A, ST_STORE_B: begin ser_clk = fall_q; ser_store = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/led_shift_ctrl.sv
module led_shift_ctrl
    import stp_pkg::*;
#(
    parameter int unsigned DIV_R0 = 50_000_000,
    parameter int unsigned DIV_R1 = 25_000_000,
    parameter int unsigned DIV_R2 = 12_500_000,
    parameter int unsigned DIV_R3 = 10_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  modem_led,
    input  logic [2:0]  phy_a_led,
    input  logic [2:0]  phy_b_led,
    output logic        ser_data,
    output logic        ser_clk,
    output logic        ser_store
);
    localparam int unsigned GROUP_W = 8;
    localparam int unsigned NGROUPS = 3;
    localparam int unsigned MAX_BITS = GROUP_W * NGROUPS;

    logic [31:0] ctrl_a_q, ctrl_b_q, pattern_q;
    logic sw_trig, tick, seq_busy, auto_en;
    logic [MAX_BITS-1:0] frame;
    logic [7:0] ovr_en, ovr_val;

    stp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_a(ctrl_a_q),
        .ctrl_b(ctrl_b_q), .pattern(pattern_q), .sw_trig(sw_trig)
    );

    assign auto_en = (ctrl_b_q[31:30] == 2'b10);

    stp_rate_timer #(.DIV_R0(DIV_R0), .DIV_R1(DIV_R1), .DIV_R2(DIV_R2), .DIV_R3(DIV_R3)) u_timer (
        .clk(clk), .rst_n(rst_n), .enable(auto_en), .rate(ctrl_b_q[24:23]), .tick(tick)
    );

    assign ovr_en  = {ctrl_b_q[17:15], ctrl_a_q[29:27], ctrl_a_q[25:24]};
    assign ovr_val = {phy_b_led, phy_a_led, modem_led};

    generate
        for (genvar b = 0; b < MAX_BITS; b++) begin : g_frame
            if (b < 8) begin : g_ovr
                assign frame[b] = ovr_en[b] ? ovr_val[b] : pattern_q[b];
            end else begin : g_plain
                assign frame[b] = pattern_q[b];
            end
        end
    endgenerate

    stp_shifter #(.GROUP_W(GROUP_W), .NGROUPS(NGROUPS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(sw_trig || tick),
        .groups(ctrl_b_q[NGROUPS-1:0]), .frame(frame), .fall_cfg(ctrl_a_q[26]),
        .busy(seq_busy), .ser_data(ser_data), .ser_clk(ser_clk), .ser_store(ser_store)
    );
endmodule

// File: rtl/stp_checks.sv
module stp_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic [2:0] groups,
    input logic       fall_cfg,
    input logic       ser_data,
    input logic       ser_clk,
    input logic       ser_store
);
    p_idle_no_groups_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && groups == 3'b000) |=> !busy);

    p_data_low_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_store |-> !ser_data);

    p_capture_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!fall_cfg && $rose(ser_clk)) || (fall_cfg && $fell(ser_clk))) |-> $stable(ser_data));

    p_store_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_store) |=> ser_store);

    p_store_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_store && $past(ser_store)) |=> !ser_store);

    p_store_clk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_store && $past(ser_store)) |-> $stable(ser_clk));
endmodule

bind led_shift_ctrl stp_checks u_checks (
    .clk(clk), .rst_n(rst_n), .busy(seq_busy), .groups(ctrl_b_q[2:0]),
    .fall_cfg(ctrl_a_q[26]), .ser_data(ser_data), .ser_clk(ser_clk), .ser_store(ser_store)
);

// File: tb/test_led_shift_ctrl.sv
module test_led_shift_ctrl;
    localparam int D0 = 300, D1 = 220, D2 = 160, D3 = 120;

    logic clk = 0, rst_n = 0;
    logic [4:0] bus_addr = 0;
    logic bus_wr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [1:0] modem_led = 0;
    logic [2:0] phy_a_led = 0, phy_b_led = 0;
    logic ser_data, ser_clk, ser_store;

    int total = 0, bad = 0, cycles = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    led_shift_ctrl #(.DIV_R0(D0), .DIV_R1(D1), .DIV_R2(D2), .DIV_R3(D3)) i_led_shift_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .modem_led(modem_led), .phy_a_led(phy_a_led), .phy_b_led(phy_b_led),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_store(ser_store)
    );

    // behavioural reference: queue of expected {data,clk,store} per cycle, -1 = idle
    int q[$];
    int exp_v = -1;
    bit pend = 0;
    int mcnt = 0;
    logic [31:0] c_a = 0, c_b = 0, pat = 0;

    function automatic int lim_of(logic [1:0] r);
        case (r)
            2'd0: return D0;
            2'd1: return D1;
            2'd2: return D2;
            default: return D3;
        endcase
    endfunction

    task automatic build_frame();
        int n;
        logic [23:0] w;
        bit f;
        n = c_b[2] ? 24 : c_b[1] ? 16 : 8;
        w = pat[23:0];
        for (int b = 0; b < 2; b++) if (c_a[24+b]) w[b] = modem_led[b];
        for (int b = 0; b < 3; b++) if (c_a[27+b]) w[2+b] = phy_a_led[b];
        for (int b = 0; b < 3; b++) if (c_b[15+b]) w[5+b] = phy_b_led[b];
        f = c_a[26];
        for (int i = n - 1; i >= 0; i--) begin
            q.push_back(int'(w[i]) * 4 + int'(f) * 2);
            q.push_back(int'(w[i]) * 4 + int'(!f) * 2);
        end
        q.push_back(int'(f) * 2 + 1);
        q.push_back(int'(f) * 2 + 1);
        q.push_back(-1);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); pend = 0; mcnt = 0; c_a = 0; c_b = 0; pat = 0; exp_v = -1;
        end else begin
            bit auto_m, tk, sw;
            auto_m = (c_b[31:30] == 2'b10);
            tk = auto_m && (mcnt == lim_of(c_b[24:23]) - 1);
            mcnt = auto_m ? (tk ? 0 : mcnt + 1) : 0;
            sw = bus_wr && bus_addr == 5'h00 && bus_wdata[31];
            if (q.size() == 0) begin
                if (sw || tk || pend) begin
                    pend = 0;
                    if (c_b[2:0] != 0) build_frame();
                end
            end else if (sw || tk) pend = 1;
            exp_v = (q.size() > 0) ? q.pop_front() : -1;
            if (bus_wr) begin
                if (bus_addr == 5'h00) c_a = bus_wdata;
                if (bus_addr == 5'h04) c_b = bus_wdata;
                if (bus_addr == 5'h08) pat = bus_wdata;
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            int e, a;
            e = (exp_v < 0) ? int'(c_a[26]) * 2 : exp_v;
            a = int'(ser_data) * 4 + int'(ser_clk) * 2 + int'(ser_store);
            total++;
            if (a != e) begin
                bad++;
                $display("FAIL %s cycle %0d pins{data,clk,store} actual=%03b expected=%03b", tag, cycles, a[2:0], e[2:0]);
            end
        end
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog expired at cycle %0d actual=hung expected=done", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_check(input logic [4:0] a, input logic [31:0] e, input string r);
        @(negedge clk);
        bus_addr = a;
        #1;
        total++;
        if (bus_rdata !== e) begin
            bad++;
            $display("FAIL %s read 0x%02h actual=%08h expected=%08h", r, a, bus_rdata, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1";
        rd_check(5'h00, 0, "R1"); rd_check(5'h04, 0, "R1"); rd_check(5'h08, 0, "R1");
        rd_check(5'h0C, 0, "R1"); rd_check(5'h10, 0, "R1");

        tag = "R2";
        wr(5'h0C, 32'hDEAD_BEEF); rd_check(5'h0C, 32'hDEAD_BEEF, "R2");
        wr(5'h10, 32'h1234_5678); rd_check(5'h10, 32'h1234_5678, "R2");
        wr(5'h08, 32'hFFFF_FFFF); rd_check(5'h08, 32'hFFFF_FFFF, "R2");
        rd_check(5'h14, 0, "R2");

        tag = "R3";  // no group: trigger dropped
        wr(5'h00, 32'h8000_0000); idle(20);
        rd_check(5'h00, 32'h8000_0000, "R2");

        tag = "R5";  // 8-bit frame
        wr(5'h08, 32'h0000_00A5); wr(5'h04, 32'h0000_0001);
        wr(5'h00, 32'h8000_0000); idle(30);
        tag = "R3";  // 24 bits, 16 bits
        wr(5'h08, 32'h00C3_5A81); wr(5'h04, 32'h0000_0004);
        wr(5'h00, 32'h8000_0000); idle(60);
        wr(5'h04, 32'h0000_0003);
        wr(5'h00, 32'h8000_0000); idle(45);

        tag = "R6";  // falling-edge capture
        wr(5'h00, 32'h0400_0000); idle(3);
        wr(5'h00, 32'h8400_0000); idle(45);
        wr(5'h00, 32'h0000_0000); idle(3);

        tag = "R7";
        wr(5'h08, 32'h0000_0000); wr(5'h04, 32'h0000_0001);
        modem_led = 2'b11; phy_a_led = 3'b101; phy_b_led = 3'b110;
        wr(5'h00, 32'h8100_0000); idle(30);
        tag = "R8";
        wr(5'h04, 32'h0003_8001);
        wr(5'h00, 32'h8800_0000); idle(30);
        wr(5'h00, 32'hBB00_0000); idle(30);
        modem_led = 0; phy_a_led = 0; phy_b_led = 0;
        wr(5'h00, 32'h0000_0000); wr(5'h04, 32'h0000_0001); idle(3);

        tag = "R12";  // pending merge
        wr(5'h08, 32'h0000_0096);
        wr(5'h00, 32'h8000_0000); idle(2);
        wr(5'h00, 32'h8000_0000); wr(5'h00, 32'h8000_0000); idle(60);

        tag = "R9";
        for (int r = 0; r < 4; r++) begin
            wr(5'h04, 32'h8000_0001 | (32'(r) << 23));
            idle(700);
        end
        tag = "R10";
        wr(5'h04, 32'h4000_0001); idle(700);
        wr(5'h04, 32'hC000_0001); idle(400);
        tag = "R11";
        wr(5'h04, 32'h8000_0002); idle(500);
        wr(5'h04, 32'h0000_0002); idle(60);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule